// File: doc/BRIEF.md
# Network Board Control and Parity Error Capture

This block is the host-visible control and status register set of a network interface board. Software uses it to hold the network controller in reset and to switch the transceiver between loopback and on-air operation. It also raises the controller's channel attention line and enables the two interrupt sources. The same registers report the controller's interrupt request and the RAM parity error flag.

When the board RAM reports a parity error, the block records the first error: which side caused it, which byte of the 16-bit word failed, and the full 20-bit failing address. It keeps that record, and ignores later errors, until software writes an acknowledge bit. The host port is a 16-bit register port with per-byte write enables, so both 8-bit and 16-bit accesses work. Reads return the selected register on `rd_data` in the same cycle.

Register select (`reg_sel`): 0 is the status register, 1 is the parity control register, 2 is the low half of the failing address, and 3 reads as zero and ignores writes.

Top module: `nbc_board_ctl`

## Requirements
- R1: After reset, `ctl_reset`, `on_air`, `attn_pulse`, `aux_bus_en` and `irq_out` are 0. The status register reads only its strap bits, and both parity registers read 0.
- R2: On a write, `wr_be[1]` enables bits 15:8 and `wr_be[0]` enables bits 7:0. A byte whose enable is 0 keeps its old contents.
- R3: Status bit 15 drives `ctl_reset`, bit 14 drives `on_air`, and bit 5 drives `aux_bus_en`. Bits 12 and 11 hold the interrupt enable and the parity interrupt enable. All of them keep their written value until rewritten, so a 1 written to bit 15 holds the controller in reset until a later write clears it.
- R4: `attn_pulse` is high for exactly one cycle, the cycle after a status write that clears bit 13 while it was set. No other write produces a pulse.
- R5: Status bit 8 (interrupt flag) shows `ctl_irq_in` one cycle later.
- R6: `irq_out` is (status bit 8 AND bit 12) OR (status bit 9 AND bit 11). With both enables clear, it stays 0.
- R7: A parity error sets status bit 9 one cycle later and records the error fields. Parity control bit 7 holds the source and bit 6 holds the byte lane. Bits 3:0 hold address bits 19:16, and register 2 holds address bits 15:0.
- R8: While status bit 9 is set, later parity errors change neither the flag nor the recorded fields.
- R9: Writing 1 to parity control bit 8 (byte lane 1 enabled) clears bit 9 and zeroes the recorded fields. Bit 8 always reads 0.
- R10: If an acknowledge and a new parity error occur in the same cycle, the new error is recorded and bit 9 stays set.
- R11: Status bits 3:0 show `strap_haddr` and bit 4 shows `strap_bigram`. Writes do not change these bits, or bits 10, 9, 8, 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select for read and write |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte write enables (1: bits 15:8, 0: bits 7:0) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| ctl_irq_in | input | 1 | Interrupt request from the network controller |
| par_err_in | input | 1 | Parity error event from the RAM |
| par_src_in | input | 1 | Side that caused the parity error |
| par_lane_in | input | 1 | Byte of the word that failed |
| par_addr_in | input | 20 | Failing RAM address |
| strap_haddr | input | 4 | RAM base address strap bits |
| strap_bigram | input | 1 | Large-RAM strap |
| ctl_reset | output | 1 | Controller reset |
| on_air | output | 1 | 1 = on-air, 0 = loopback |
| attn_pulse | output | 1 | One-cycle channel attention pulse |
| aux_bus_en | output | 1 | Auxiliary bus enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a write of the parity acknowledge and a new parity error. The bench provokes this by driving the acknowledge write and a new error event, with address and fields different from the recorded ones, on the same clock edge. It then requires the flag to stay set and the parity registers to read the new fields. The bench also sends a second error while the flag is held and checks that the recorded fields do not change.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_PCTRL  = 2'd1,
    SEL_PADDR  = 2'd2,
    SEL_NONE   = 2'd3
  } nbc_sel_e;

  // bit positions inside the high byte of the status register
  localparam int HB_RESET = 7;
  localparam int HB_ONAIR = 6;
  localparam int HB_ATTN  = 5;
  localparam int HB_IEN   = 4;
  localparam int HB_PIEN  = 3;
  // bit position inside the low byte
  localparam int LB_AUX   = 5;
  // acknowledge position inside the high byte of parity control
  localparam int HB_ACK   = 0;
endpackage

// File: rtl/nbc_rst_sync.sv
module nbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/nbc_ctrl_regs.sv
module nbc_ctrl_regs
  import nbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [7:0] wdata_hi,
  input  logic       wdata_aux,
  input  logic       irq_evt,
  output logic       ctl_reset,
  output logic       on_air,
  output logic       attn_q,
  output logic       ien,
  output logic       pien,
  output logic       aux_en,
  output logic       intf,
  output logic       attn_pulse
);
  logic rst_d, air_d, attn_d, ien_d, pien_d, aux_d, intf_d, pulse_d;

  always_comb begin
    rst_d   = ctl_reset;
    air_d   = on_air;
    attn_d  = attn_q;
    ien_d   = ien;
    pien_d  = pien;
    aux_d   = aux_en;
    if (wr_hi) begin
      rst_d  = wdata_hi[HB_RESET];
      air_d  = wdata_hi[HB_ONAIR];
      attn_d = wdata_hi[HB_ATTN];
      ien_d  = wdata_hi[HB_IEN];
      pien_d = wdata_hi[HB_PIEN];
    end
    if (wr_lo) aux_d = wdata_aux;
    pulse_d = wr_hi & attn_q & ~wdata_hi[HB_ATTN];
    intf_d  = irq_evt;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctl_reset  <= 1'b0;
      on_air     <= 1'b0;
      attn_q     <= 1'b0;
      ien        <= 1'b0;
      pien       <= 1'b0;
      aux_en     <= 1'b0;
      intf       <= 1'b0;
      attn_pulse <= 1'b0;
    end else begin
      ctl_reset  <= rst_d;
      on_air     <= air_d;
      attn_q     <= attn_d;
      ien        <= ien_d;
      pien       <= pien_d;
      aux_en     <= aux_d;
      intf       <= intf_d;
      attn_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/nbc_par_cap.sv
module nbc_par_cap #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              err_in,
  input  logic              src_in,
  input  logic              lane_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ack,
  output logic              flag_q,
  output logic              src_q,
  output logic              lane_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic              take;
  logic              flag_d, src_d, lane_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    take   = err_in & (~flag_q | ack);
    flag_d = take | (flag_q & ~ack);
    if (take) begin
      src_d  = src_in;
      lane_d = lane_in;
      addr_d = addr_in;
    end else if (ack) begin
      src_d  = 1'b0;
      lane_d = 1'b0;
      addr_d = '0;
    end else begin
      src_d  = src_q;
      lane_d = lane_q;
      addr_d = addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flag_q <= 1'b0;
      src_q  <= 1'b0;
      lane_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flag_q <= flag_d;
      src_q  <= src_d;
      lane_q <= lane_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/nbc_board_ctl.sv
module nbc_board_ctl
  import nbc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int STRAP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic              ctl_irq_in,
  input  logic              par_err_in,
  input  logic              par_src_in,
  input  logic              par_lane_in,
  input  logic [ADDR_W-1:0] par_addr_in,
  input  logic [STRAP_W-1:0] strap_haddr,
  input  logic              strap_bigram,
  output logic              ctl_reset,
  output logic              on_air,
  output logic              attn_pulse,
  output logic              aux_bus_en,
  output logic              irq_out
);
  localparam int LO_W = 16;
  localparam int HI_W = ADDR_W - LO_W;

  logic              rst_sn;
  logic              wr_status_hi, wr_status_lo, ack_hit;
  logic              attn_q, ien, pien, intf;
  logic              perr_q, psrc_q, plane_q;
  logic [ADDR_W-1:0] cap_addr;
  logic              unused_wr;

  nbc_rst_sync u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  always_comb begin
    wr_status_hi = wr_en && (reg_sel == SEL_STATUS) && wr_be[1];
    wr_status_lo = wr_en && (reg_sel == SEL_STATUS) && wr_be[0];
    ack_hit      = wr_en && (reg_sel == SEL_PCTRL) && wr_be[1]
                   && wr_data[8 + HB_ACK];
  end

  assign unused_wr = ^{wr_data[10:9], wr_data[7:6], wr_data[4:0]};

  nbc_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .wr_hi      (wr_status_hi),
    .wr_lo      (wr_status_lo),
    .wdata_hi   (wr_data[15:8]),
    .wdata_aux  (wr_data[LB_AUX]),
    .irq_evt    (ctl_irq_in),
    .ctl_reset  (ctl_reset),
    .on_air     (on_air),
    .attn_q     (attn_q),
    .ien        (ien),
    .pien       (pien),
    .aux_en     (aux_bus_en),
    .intf       (intf),
    .attn_pulse (attn_pulse)
  );

  nbc_par_cap #(.ADDR_W(ADDR_W)) u_par (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .err_in  (par_err_in),
    .src_in  (par_src_in),
    .lane_in (par_lane_in),
    .addr_in (par_addr_in),
    .ack     (ack_hit),
    .flag_q  (perr_q),
    .src_q   (psrc_q),
    .lane_q  (plane_q),
    .addr_q  (cap_addr)
  );

  assign irq_out = (intf & ien) | (perr_q & pien);

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      SEL_STATUS: begin
        rd_data[15]          = ctl_reset;
        rd_data[14]          = on_air;
        rd_data[13]          = attn_q;
        rd_data[12]          = ien;
        rd_data[11]          = pien;
        rd_data[9]           = perr_q;
        rd_data[8]           = intf;
        rd_data[5]           = aux_bus_en;
        rd_data[4]           = strap_bigram;
        rd_data[STRAP_W-1:0] = strap_haddr;
      end
      SEL_PCTRL: begin
        rd_data[7]        = psrc_q;
        rd_data[6]        = plane_q;
        rd_data[HI_W-1:0] = cap_addr[ADDR_W-1:LO_W];
      end
      SEL_PADDR: rd_data = cap_addr[LO_W-1:0];
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/nbc_board_ctl_chk.sv
module nbc_board_ctl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              wr_status_hi,
  input logic              ack_hit,
  input logic              par_err_in,
  input logic              attn_q,
  input logic              attn_pulse,
  input logic              ctl_reset,
  input logic              ien,
  input logic              pien,
  input logic              irq_out,
  input logic              perr_q,
  input logic [ADDR_W-1:0] cap_addr
);
  p_reset_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctl_reset && !wr_status_hi) |=> ctl_reset);

  p_attn_single_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    attn_pulse |=> !attn_pulse);

  p_attn_cause_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    attn_pulse |-> $fell(attn_q));

  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ien && !pien) |-> !irq_out);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (perr_q && !ack_hit) |=> (perr_q && $stable(cap_addr)));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_hit && !par_err_in) |=> !perr_q);

  p_ack_collide_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_hit && par_err_in) |=> perr_q);
endmodule

bind nbc_board_ctl nbc_board_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .wr_status_hi (wr_status_hi),
  .ack_hit      (ack_hit),
  .par_err_in   (par_err_in),
  .attn_q       (attn_q),
  .attn_pulse   (attn_pulse),
  .ctl_reset    (ctl_reset),
  .ien          (ien),
  .pien         (pien),
  .irq_out      (irq_out),
  .perr_q       (perr_q),
  .cap_addr     (cap_addr)
);

// File: tb/sim_nbc_board_ctl.sv
`timescale 1ns/1ps
module sim_nbc_board_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  reg_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        ctl_irq_in = 1'b0;
  logic        par_err_in = 1'b0;
  logic        par_src_in = 1'b0;
  logic        par_lane_in = 1'b0;
  logic [19:0] par_addr_in = 20'h0;
  logic [3:0]  strap_haddr = 4'hA;
  logic        strap_bigram = 1'b1;
  logic        ctl_reset, on_air, attn_pulse, aux_bus_en, irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nbc_board_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .ctl_irq_in(ctl_irq_in), .par_err_in(par_err_in),
    .par_src_in(par_src_in), .par_lane_in(par_lane_in),
    .par_addr_in(par_addr_in), .strap_haddr(strap_haddr),
    .strap_bigram(strap_bigram), .ctl_reset(ctl_reset), .on_air(on_air),
    .attn_pulse(attn_pulse), .aux_bus_en(aux_bus_en), .irq_out(irq_out)
  );

  // {sel, be, wdata, expected readback of the same register}
  localparam logic [35:0] VEC [8] = '{
    {2'd0, 2'b11, 16'h4000, 16'h401A},
    {2'd0, 2'b01, 16'hFFFF, 16'h403A},
    {2'd0, 2'b10, 16'h0000, 16'h003A},
    {2'd0, 2'b11, 16'h1800, 16'h181A},
    {2'd0, 2'b10, 16'hFFFF, 16'hF81A},
    {2'd0, 2'b11, 16'h0000, 16'h001A},
    {2'd1, 2'b11, 16'hFEFF, 16'h0000},
    {2'd2, 2'b11, 16'hFFFF, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] be,
                    input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; wr_be = be; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic perr(input logic s, input logic l, input logic [19:0] a);
    @(negedge clk);
    par_err_in = 1'b1; par_src_in = s; par_lane_in = l; par_addr_in = a;
    @(negedge clk);
    par_err_in = 1'b0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 status", v, 16'h001A);
    rd(2'd1, v); check("R1 pctrl", v, 16'h0000);
    rd(2'd2, v); check("R1 paddr", v, 16'h0000);
    check("R1 outputs", {11'd0, ctl_reset, on_air, attn_pulse, aux_bus_en, irq_out}, 16'h0);

    // R2/R3/R11 vector table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][35:34], VEC[i][33:32], VEC[i][31:16]);
      rd(VEC[i][35:34], v);
      check($sformatf("R2 R3 R11 vector %0d", i), v, VEC[i][15:0]);
    end

    // R3 reset held across unrelated writes
    wr(2'd0, 2'b11, 16'h8000);
    check("R3 reset set", {15'd0, ctl_reset}, 16'h1);
    wr(2'd0, 2'b01, 16'h0020);
    check("R3 reset held", {15'd0, ctl_reset}, 16'h1);
    check("R3 aux out", {15'd0, aux_bus_en}, 16'h1);
    wr(2'd0, 2'b11, 16'h4000);
    check("R3 reset released, on_air", {14'd0, ctl_reset, on_air}, 16'h1);

    // R4 attention pulse
    wr(2'd0, 2'b10, 16'h2000);
    check("R4 no pulse on set", {15'd0, attn_pulse}, 16'h0);
    wr(2'd0, 2'b01, 16'h0000);
    check("R4 no pulse low byte", {15'd0, attn_pulse}, 16'h0);
    rd(2'd0, v); check("R4 attn still set", v & 16'h2000, 16'h2000);
    wr(2'd0, 2'b10, 16'h0000);
    check("R4 pulse", {15'd0, attn_pulse}, 16'h1);
    @(negedge clk);
    check("R4 pulse one cycle", {15'd0, attn_pulse}, 16'h0);
    wr(2'd0, 2'b10, 16'h0000);
    check("R4 no pulse when clear", {15'd0, attn_pulse}, 16'h0);

    // R5/R6 interrupt flag and merge
    @(negedge clk); ctl_irq_in = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R5 int flag", v & 16'h0100, 16'h0100);
    check("R6 irq masked", {15'd0, irq_out}, 16'h0);
    wr(2'd0, 2'b10, 16'h1000);
    check("R6 irq enabled", {15'd0, irq_out}, 16'h1);
    @(negedge clk); ctl_irq_in = 1'b0;
    @(negedge clk);
    check("R5 R6 flag follows", {15'd0, irq_out}, 16'h0);

    // R7 capture
    wr(2'd0, 2'b10, 16'h0800);
    perr(1'b1, 1'b0, 20'h51234);
    rd(2'd0, v); check("R7 perr flag", v & 16'h0200, 16'h0200);
    rd(2'd1, v); check("R7 pctrl", v, 16'h0085);
    rd(2'd2, v); check("R7 paddr", v, 16'h1234);
    check("R6 parity irq", {15'd0, irq_out}, 16'h1);

    // R8 freeze
    perr(1'b0, 1'b1, 20'hC0FFE);
    rd(2'd1, v); check("R8 pctrl frozen", v, 16'h0085);
    rd(2'd2, v); check("R8 paddr frozen", v, 16'h1234);

    // R9 acknowledge
    wr(2'd1, 2'b01, 16'hFFFF);
    rd(2'd0, v); check("R9 low-byte ack ignored", v & 16'h0200, 16'h0200);
    wr(2'd1, 2'b10, 16'h0100);
    rd(2'd0, v); check("R9 flag cleared", v & 16'h0200, 16'h0000);
    rd(2'd1, v); check("R9 pctrl zero, ack reads 0", v, 16'h0000);
    rd(2'd2, v); check("R9 paddr zero", v, 16'h0000);
    check("R9 irq dropped", {15'd0, irq_out}, 16'h0);

    // R10 ack and new error in the same cycle
    perr(1'b0, 1'b0, 20'h1AAAA);
    @(negedge clk);
    reg_sel = 2'd1; wr_be = 2'b10; wr_data = 16'h0100; wr_en = 1'b1;
    par_err_in = 1'b1; par_src_in = 1'b1; par_lane_in = 1'b1;
    par_addr_in = 20'h7BEEF;
    @(negedge clk);
    wr_en = 1'b0; par_err_in = 1'b0;
    rd(2'd0, v); check("R10 flag kept", v & 16'h0200, 16'h0200);
    rd(2'd1, v); check("R10 new pctrl", v, 16'h00C7);
    rd(2'd2, v); check("R10 new paddr", v, 16'hBEEF);

    // R11 strap changes visible, write ignored
    strap_haddr = 4'h3; strap_bigram = 1'b0;
    wr(2'd0, 2'b01, 16'h001F);
    rd(2'd0, v); check("R11 straps", v & 16'h001F, 16'h0003);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule